// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block sits after a Reed-Solomon decoder for a 2048-byte flash page. The decoder hands over at most four pairs, each made of an error location and a 12-bit error value. The page is covered as a run of 12-bit symbols packed back to back over the data bytes and then the spare bytes. For each pair, the block works out which one or two bytes of the page buffer the symbol touches. It then XORs the nibble-aligned parts of the error value into those bytes. Every byte update is a read-modify-write on an external synchronous buffer port. That port has a region flag to pick the data area or the spare area, and a byte offset inside that area.

Pairs arrive on a valid/ready stream. A last marker closes each page. Once the last pair of a page has been handled, the block pulses a done strobe with either the number of symbols it corrected or a failure flag. Root finding and syndrome computation happen upstream.

Top module: `rsfix_apply`

## Requirements
- R1: For an odd location p whose byte index floor(3p/2) is below 2047, value bits 11:4 XOR into data byte floor(3p/2). Value bits 3:0 XOR into the upper nibble (bits 7:4) of the following byte.
- R2: For an even location p from 2 to 1364, value bits 11:8 XOR into the lower nibble (bits 3:0) of data byte 3p/2-1. Value bits 7:0 XOR into data byte 3p/2.
- R3: Location 0 touches only data byte 0, which takes value bits 7:0. Data byte 1 is left unchanged.
- R4: A location-0 pair whose value has any of bits 11:8 set fails the page and writes nothing.
- R5: Location 1365 XORs value bits 11:4 into data byte 2047 and value bits 3:0 into the upper nibble of spare byte 0.
- R6: Locations from 1366 to 1374 use the same odd/even rule on a page-wide byte index. Index 2048 and above addresses spare byte (index-2048) with the region flag high.
- R7: A location above 1374 fails the page and writes nothing.
- R8: A page corrects at most 4 symbols. A fifth accepted pair fails the page and writes nothing, while the first four stay applied.
- R9: After the last pair of a page, done is high for exactly one cycle. When the page has not failed, count equals the number of pairs applied and fail is 0. When it has failed, fail is 1 and count is 0.
- R10: Each byte update is a read cycle followed by a write cycle to the same region and offset, with write data equal to read data XOR pattern. Ready is low while an update is in progress.
- R11: After a page has failed, its later pairs cause no buffer writes. The next page starts with a zero count and no failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Location/value pair is offered |
| in_ready | output | 1 | Block accepts a pair this cycle |
| in_pos | input | 11 | Symbol location |
| in_val | input | 12 | Symbol error value |
| in_last | input | 1 | Pair is the final one of the page |
| buf_rd_en | output | 1 | Buffer read strobe (data returned next cycle) |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_spare | output | 1 | Region flag: 1 = spare area, 0 = data area |
| buf_addr | output | 11 | Byte offset inside the selected region |
| buf_rdata | input | 8 | Read data, one cycle after buf_rd_en |
| buf_wdata | output | 8 | Corrected byte to write |
| done | output | 1 | One-cycle page completion strobe |
| fail | output | 1 | Page uncorrectable, valid with done |
| cnt | output | 3 | Corrected symbol count, valid with done |

## Verification
The assertions assume three things about the buffer and the stream. The buffer port returns read data exactly one cycle after a read strobe. Stream inputs hold steady while valid waits for ready. Each page ends with a pair marked last before the next page starts. The bench models the buffer as a synchronous memory with that one-cycle latency, drives pairs on falling edges and keeps them until the handshake completes. It does not offer a new page until the done strobe of the previous one has been seen.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;
    localparam int POS_W   = 11;
    localparam int SYM_W   = 12;
    localparam int BYTE_W  = 8;
    localparam int GADDR_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_WR0,
        ST_RD1,
        ST_WR1,
        ST_REPORT
    } rsfix_state_e;

    typedef struct packed {
        logic [GADDR_W-1:0] addr0;
        logic [BYTE_W-1:0]  pat0;
        logic [GADDR_W-1:0] addr1;
        logic [BYTE_W-1:0]  pat1;
        logic               two;
        logic               reject;
    } rsfix_plan_t;

    function automatic logic [GADDR_W-1:0] three_halves(input logic [POS_W-1:0] p);
        return GADDR_W'(p) + GADDR_W'(p[POS_W-1:1]);
    endfunction
endpackage

// File: rtl/rsfix_map.sv
module rsfix_map
    import rsfix_pkg::*;
#(
    parameter int MAX_POS = 1374
) (
    input  logic [POS_W-1:0] pos,
    input  logic [SYM_W-1:0] val,
    output rsfix_plan_t      plan
);
    logic [GADDR_W-1:0] half;

    always_comb begin
        half = three_halves(pos);
        plan = '0;
        if (pos == '0) begin
            plan.addr0  = '0;
            plan.pat0   = val[7:0];
            plan.two    = 1'b0;
            plan.reject = |val[SYM_W-1:8];
        end else if (pos[0]) begin
            plan.addr0 = half;
            plan.pat0  = val[SYM_W-1:4];
            plan.addr1 = half + GADDR_W'(1);
            plan.pat1  = {val[3:0], 4'h0};
            plan.two   = 1'b1;
        end else begin
            plan.addr0 = half - GADDR_W'(1);
            plan.pat0  = {4'h0, val[SYM_W-1:8]};
            plan.addr1 = half;
            plan.pat1  = val[7:0];
            plan.two   = 1'b1;
        end
        if (pos > POS_W'(MAX_POS))
            plan.reject = 1'b1;
    end
endmodule

// File: rtl/rsfix_bufport.sv
module rsfix_bufport
    import rsfix_pkg::*;
#(
    parameter int DATA_BYTES = 2048,
    parameter int ADDR_W     = $clog2(DATA_BYTES)
) (
    input  logic [GADDR_W-1:0] gaddr,
    output logic               spare,
    output logic [ADDR_W-1:0]  addr
);
    generate
        if (DATA_BYTES == (1 << ADDR_W) && GADDR_W == ADDR_W + 1) begin : g_pow2
            assign spare = gaddr[ADDR_W];
            assign addr  = gaddr[ADDR_W-1:0];
        end else begin : g_generic
            logic [GADDR_W-1:0] off;
            always_comb begin
                spare = (gaddr >= GADDR_W'(DATA_BYTES));
                off   = spare ? (gaddr - GADDR_W'(DATA_BYTES)) : gaddr;
                addr  = off[ADDR_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/rsfix_ctrl.sv
module rsfix_ctrl
    import rsfix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int CNT_W   = $clog2(MAX_ERR + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_last,
    output logic               in_ready,
    input  rsfix_plan_t        plan_i,
    input  logic [BYTE_W-1:0]  rdata,
    output logic               rd_en,
    output logic               wr_en,
    output logic [GADDR_W-1:0] gaddr,
    output logic [BYTE_W-1:0]  wdata,
    output logic               done,
    output logic               fail,
    output logic [CNT_W-1:0]   cnt
);
    rsfix_state_e state;
    rsfix_plan_t  plan_q;
    logic         last_q;
    logic         fail_q;
    logic [CNT_W-1:0] cnt_q;
    logic         accept;
    logic         second;

    assign accept = in_valid && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            plan_q <= '0;
            last_q <= 1'b0;
            fail_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        plan_q <= plan_i;
                        last_q <= in_last;
                        if (fail_q || plan_i.reject || cnt_q == CNT_W'(MAX_ERR)) begin
                            fail_q <= 1'b1;
                            state  <= in_last ? ST_REPORT : ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                            state <= ST_RD0;
                        end
                    end
                end
                ST_RD0:  state <= ST_WR0;
                ST_WR0:  state <= plan_q.two ? ST_RD1 : (last_q ? ST_REPORT : ST_IDLE);
                ST_RD1:  state <= ST_WR1;
                ST_WR1:  state <= last_q ? ST_REPORT : ST_IDLE;
                ST_REPORT: begin
                    fail_q <= 1'b0;
                    cnt_q  <= '0;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        second   = (state == ST_RD1) || (state == ST_WR1);
        in_ready = (state == ST_IDLE);
        rd_en    = (state == ST_RD0) || (state == ST_RD1);
        wr_en    = (state == ST_WR0) || (state == ST_WR1);
        gaddr    = second ? plan_q.addr1 : plan_q.addr0;
        wdata    = rdata ^ (second ? plan_q.pat1 : plan_q.pat0);
        done     = (state == ST_REPORT);
        fail     = done && fail_q;
        cnt      = (done && !fail_q) ? cnt_q : '0;
    end
endmodule

// File: rtl/rsfix_apply.sv
module rsfix_apply
    import rsfix_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int MAX_POS     = 1374,
    parameter int MAX_ERR     = 4,
    parameter int ADDR_W      = $clog2(DATA_BYTES),
    parameter int CNT_W       = $clog2(MAX_ERR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [POS_W-1:0]  in_pos,
    input  logic [SYM_W-1:0]  in_val,
    input  logic              in_last,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic              buf_spare,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              done,
    output logic              fail,
    output logic [CNT_W-1:0]  cnt
);
    rsfix_plan_t        plan;
    logic [GADDR_W-1:0] gaddr;

    rsfix_map #(.MAX_POS(MAX_POS)) u_map (
        .pos  (in_pos),
        .val  (in_val),
        .plan (plan)
    );

    rsfix_ctrl #(.MAX_ERR(MAX_ERR), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .plan_i   (plan),
        .rdata    (buf_rdata),
        .rd_en    (buf_rd_en),
        .wr_en    (buf_wr_en),
        .gaddr    (gaddr),
        .wdata    (buf_wdata),
        .done     (done),
        .fail     (fail),
        .cnt      (cnt)
    );

    rsfix_bufport #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) u_port (
        .gaddr (gaddr),
        .spare (buf_spare),
        .addr  (buf_addr)
    );
endmodule

// File: rtl/rsfix_apply_chk.sv
module rsfix_apply_chk
    import rsfix_pkg::*;
#(
    parameter int SPARE_BYTES = 64,
    parameter int MAX_POS     = 1374,
    parameter int MAX_ERR     = 4,
    parameter int ADDR_W      = 11,
    parameter int CNT_W       = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [POS_W-1:0]  in_pos,
    input logic [SYM_W-1:0]  in_val,
    input logic              buf_rd_en,
    input logic              buf_wr_en,
    input logic              buf_spare,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              done,
    input logic              fail,
    input logic [CNT_W-1:0]  cnt
);
    p_wr_follows_rd_r10: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> ($past(buf_rd_en) && $past(buf_addr) == buf_addr && $past(buf_spare) == buf_spare));

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (buf_rd_en || buf_wr_en) |-> !in_ready);

    p_pos_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_pos > POS_W'(MAX_POS)) |=> !buf_rd_en);

    p_lead_reject_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_pos == '0 && |in_val[SYM_W-1:8]) |=> !buf_rd_en);

    p_fail_zero_cnt_r9: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (cnt == '0));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_cnt_cap_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt <= CNT_W'(MAX_ERR)));

    p_spare_range_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_rd_en && buf_spare) |-> (buf_addr < ADDR_W'(SPARE_BYTES)));
endmodule

bind rsfix_apply rsfix_apply_chk #(
    .SPARE_BYTES (SPARE_BYTES),
    .MAX_POS     (MAX_POS),
    .MAX_ERR     (MAX_ERR),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pos    (in_pos),
    .in_val    (in_val),
    .buf_rd_en (buf_rd_en),
    .buf_wr_en (buf_wr_en),
    .buf_spare (buf_spare),
    .buf_addr  (buf_addr),
    .done      (done),
    .fail      (fail),
    .cnt       (cnt)
);

// File: tb/rsfix_apply_test.sv
module rsfix_apply_test;
    localparam int DB = 2048;
    localparam int SB = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [10:0] in_pos = '0;
    logic [11:0] in_val = '0;
    logic        in_last = 1'b0;
    logic        buf_rd_en, buf_wr_en, buf_spare;
    logic [10:0] buf_addr;
    logic [7:0]  buf_rdata = '0;
    logic [7:0]  buf_wdata;
    logic        done, fail;
    logic [2:0]  cnt;

    always #5 clk = ~clk;

    rsfix_apply uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pos(in_pos), .in_val(in_val), .in_last(in_last),
        .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_spare(buf_spare),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_wdata(buf_wdata),
        .done(done), .fail(fail), .cnt(cnt)
    );

    logic [7:0] dmem  [DB];
    logic [7:0] smem  [SB];
    logic [7:0] ref_d [DB];
    logic [7:0] ref_s [SB];

    int checks = 0;
    int failures = 0;
    int pages_sent = 0;
    int pages_done = 0;
    bit finished = 0;

    typedef struct {
        bit    efail;
        int    ecnt;
        string tag;
    } exp_t;
    exp_t expq[$];

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= buf_spare ? smem[buf_addr[5:0]] : dmem[buf_addr];
        if (buf_wr_en) begin
            if (buf_spare) smem[buf_addr[5:0]] <= buf_wdata;
            else           dmem[buf_addr]      <= buf_wdata;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (expq.size() == 0) begin
                check("R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " R9 fail flag"}, int'(fail), int'(e.efail));
                check({e.tag, " R9 count"}, int'(cnt), e.ecnt);
            end
            pages_done++;
        end
    end

    task automatic ref_xor(int a, logic [7:0] p);
        if (a < DB) ref_d[a] = ref_d[a] ^ p;
        else        ref_s[a - DB] = ref_s[a - DB] ^ p;
    endtask

    task automatic ref_apply(int p, int v);
        int h;
        h = (3 * p) / 2;
        if (p == 0) ref_xor(0, 8'(v));
        else if (p % 2 == 1) begin
            ref_xor(h, 8'(v >> 4));
            ref_xor(h + 1, 8'((v & 15) << 4));
        end else begin
            ref_xor(h - 1, 8'(v >> 8));
            ref_xor(h, 8'(v));
        end
    endtask

    task automatic send_pair(int p, int v, bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_pos   = 11'(p);
        in_val   = 12'(v);
        in_last  = last;
        forever begin
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_page(input string tag, input int n, input int ps[8], input int vs[8]);
        exp_t e;
        int   c;
        bit   f;
        int   bad;
        c = 0; f = 0;
        for (int i = 0; i < n; i++) begin
            if (f) continue;
            if (ps[i] > 1374 || (ps[i] == 0 && vs[i] > 255)) f = 1;
            else if (c == 4) f = 1;
            else begin
                ref_apply(ps[i], vs[i]);
                c++;
            end
        end
        e.efail = f; e.ecnt = f ? 0 : c; e.tag = tag;
        expq.push_back(e);
        pages_sent++;
        for (int i = 0; i < n; i++) send_pair(ps[i], vs[i], i == n - 1);
        wait (pages_done == pages_sent);
        @(negedge clk);
        bad = 0;
        for (int a = 0; a < DB; a++) if (dmem[a] != ref_d[a]) bad++;
        for (int a = 0; a < SB; a++) if (smem[a] != ref_s[a]) bad++;
        check({tag, " buffer mismatches"}, bad, 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int a = 0; a < DB; a++) begin dmem[a] = init_byte(a); ref_d[a] = init_byte(a); end
        for (int a = 0; a < SB; a++) begin smem[a] = init_byte(a + DB); ref_s[a] = init_byte(a + DB); end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R10 reset ready", int'(in_ready), 1);
        check("R9 reset done", int'(done), 0);
        check("R10 reset rd/wr", int'(buf_rd_en | buf_wr_en), 0);

        // R1 odd location, plus busy check for R10
        expq.push_back('{efail: 0, ecnt: 1, tag: "R1 page"});
        pages_sent++;
        ref_apply(5, 'hABC);
        send_pair(5, 'hABC, 1);
        @(negedge clk);
        check("R10 ready low while busy", int'(in_ready), 0);
        check("R10 read issued", int'(buf_rd_en), 1);
        wait (pages_done == pages_sent);
        @(negedge clk);
        check("R1 byte7", dmem[7], init_byte(7) ^ 8'hAB);
        check("R1 byte8", dmem[8], init_byte(8) ^ 8'hC0);

        run_page("R2 page", 2, '{10, 1364, 0, 0, 0, 0, 0, 0}, '{'h5A3, 'h7E1, 0, 0, 0, 0, 0, 0});
        check("R2 byte14", dmem[14], init_byte(14) ^ 8'h05);
        check("R2 byte15", dmem[15], init_byte(15) ^ 8'hA3);
        check("R2 byte2045", dmem[2045], init_byte(2045) ^ 8'h07);
        check("R2 byte2046", dmem[2046], init_byte(2046) ^ 8'hE1);

        run_page("R3 page", 1, '{0, 0, 0, 0, 0, 0, 0, 0}, '{'h0F7, 0, 0, 0, 0, 0, 0, 0});
        check("R3 byte0", dmem[0], init_byte(0) ^ 8'hF7);
        check("R3 byte1 untouched", dmem[1], init_byte(1));

        run_page("R4 page", 1, '{0, 0, 0, 0, 0, 0, 0, 0}, '{'h1F7, 0, 0, 0, 0, 0, 0, 0});
        check("R4 byte0 unchanged", dmem[0], init_byte(0) ^ 8'hF7);

        run_page("R5 page", 1, '{1365, 0, 0, 0, 0, 0, 0, 0}, '{'h9E6, 0, 0, 0, 0, 0, 0, 0});
        check("R5 byte2047", dmem[2047], init_byte(2047) ^ 8'h9E);
        check("R5 spare0", smem[0], init_byte(DB) ^ 8'h60);

        run_page("R6 page", 3, '{1367, 1370, 1374, 0, 0, 0, 0, 0}, '{'h4D2, 'h321, 'hFFF, 0, 0, 0, 0, 0});
        check("R6 spare2", smem[2], init_byte(DB + 2) ^ 8'h4D);
        check("R6 spare3", smem[3], init_byte(DB + 3) ^ 8'h20);
        check("R6 spare6", smem[6], init_byte(DB + 6) ^ 8'h03);
        check("R6 spare7", smem[7], init_byte(DB + 7) ^ 8'h21);
        check("R6 spare12", smem[12], init_byte(DB + 12) ^ 8'h0F);
        check("R6 spare13", smem[13], init_byte(DB + 13) ^ 8'hFF);

        // R7 then R11: out-of-range location fails, later pair ignored
        run_page("R7 R11 page", 2, '{1375, 101, 0, 0, 0, 0, 0, 0}, '{'h123, 'hFFF, 0, 0, 0, 0, 0, 0});
        check("R11 byte151 untouched", dmem[151], init_byte(151));

        run_page("R8 page", 5, '{21, 40, 63, 80, 99, 0, 0, 0}, '{'h111, 'h222, 'h333, 'h444, 'h555, 0, 0, 0});
        check("R8 fifth pair byte148 untouched", dmem[148], init_byte(148));

        run_page("R9 R11 four-pair page", 4, '{201, 300, 777, 1000, 0, 0, 0, 0}, '{'h001, 'h800, 'hA5A, 'h0F0, 0, 0, 0, 0});
        run_page("R9 mixed page", 3, '{501, 1380, 600, 0, 0, 0, 0, 0}, '{'h321, 'h1, 'h2, 0, 0, 0, 0, 0});
        run_page("R11 fresh page", 1, '{1201, 0, 0, 0, 0, 0, 0, 0}, '{'hBEE, 0, 0, 0, 0, 0, 0, 0});

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule